// File: doc/BRIEF.md
# 32-Source Interrupt Controller

This block gathers thirty-two interrupt request lines into one controller that a processor configures through a small word-addressed register port. Each line is given its own sensing mode and active sense. Trigger selects between edge capture and level following, and polarity selects rising/high or falling/low. Each line also has its own enable bit and its own routing choice between a critical and a non-critical processor interrupt output.

Captured requests sit in a raw status register that software clears by writing ones. A masked status view combines raw status with the enable bits. Software finds the pending source from the lowest set bit of masked status, so the outputs are a plain OR of pending, enabled lines with no priority logic. A second instance can feed one of its outputs into a request input of a first instance to form a cascade. Request inputs are taken to be synchronous to the block clock.

Top module: `irq_ctrl32`

## Requirements
- R1: Source n occupies bit 31−n of `irq_in` and of every register, so source 0 is the most significant bit and source 31 is bit 0.
- R2: While reset is asserted, and after it is released, enable, critical select, polarity, trigger, status and read data are all zero and both interrupt outputs are low.
- R3: With trigger bit 0 (level), a status bit is set at each clock edge where its input is at the active level: high when polarity is 1, low when polarity is 0. The new value shows at the ports one cycle after the input is sampled.
- R4: With trigger bit 1 (edge), a status bit is set by a 0→1 input change when polarity is 1, or by a 1→0 change when polarity is 0. The bit stays set after the input returns to its idle level.
- R5: Writing to offset 0x0 clears each status bit whose write-data bit is 1. Bits written as 0 are left unchanged.
- R6: A level-sensed status bit cannot be cleared while its input is still at the active level, whether or not the source is enabled.
- R7: When an edge event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R8: Offset 0x6 reads status AND enable. Raw status at offset 0x0 captures sources whether or not they are enabled.
- R9: `irq_crit` is high when any masked status bit has its critical select bit (offset 0x3) at 1. `irq_norm` is high when any masked status bit has its critical select bit at 0.
- R10: Enable (0x2), critical select (0x3), polarity (0x4) and trigger (0x5) read back the last value written to them.
- R11: Reads of offsets 0x7, 0x8 and every unmapped offset return zero. Writes to 0x6, 0x7, 0x8 and unmapped offsets change no register.
- R12: `reg_rdata` carries the addressed word in the cycle after a cycle with `reg_rd` high, and zero after any cycle without `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Request lines, source n on bit 31−n |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| irq_crit | output | 1 | Critical interrupt request |
| irq_norm | output | 1 | Non-critical interrupt request |

## Verification
Two functions can meet on the same status bit in one cycle: new capture from the request line, and a software clear. They meet in two ways: a clear against a line held at its active level, and a clear that lands with a fresh edge. The bench provokes each by changing `irq_in` on the same falling edge that raises a clear write to offset 0x0. It then reads status back and expects the bit to be set. Random traffic then mixes request toggles, clears, reconfiguration and reads in every cycle. A bench reference model judges the read data and both outputs after each edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NUM_SRC = 32;
  localparam int unsigned ADDR_W  = 4;

  typedef logic [NUM_SRC-1:0] srcvec_t;
  typedef logic [ADDR_W-1:0]  regofs_t;

  localparam regofs_t OFS_STAT  = 4'h0;
  localparam regofs_t OFS_EN    = 4'h2;
  localparam regofs_t OFS_CRIT  = 4'h3;
  localparam regofs_t OFS_POL   = 4'h4;
  localparam regofs_t OFS_TRIG  = 4'h5;
  localparam regofs_t OFS_MSTAT = 4'h6;
  localparam regofs_t OFS_VEC   = 4'h7;
  localparam regofs_t OFS_VCFG  = 4'h8;

  // Bit position used by source number n (MSB-first numbering).
  function automatic int unsigned src_pos(int unsigned n);
    return NUM_SRC - 1 - n;
  endfunction

  // Clear vector produced by a write cycle.
  function automatic srcvec_t clear_of(logic wr, regofs_t ofs, srcvec_t data);
    return (wr && ofs == OFS_STAT) ? data : '0;
  endfunction

  // Masked word split by routing choice.
  function automatic logic any_routed(srcvec_t pend, srcvec_t sel);
    return |(pend & sel);
  endfunction
endpackage

// File: rtl/irqc_sense.sv
module irqc_sense
  import irqc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  srcvec_t irq_in,
  input  srcvec_t trig_q,
  input  srcvec_t pol_q,
  output srcvec_t set_vec,
  output srcvec_t lvl_hold
);
  srcvec_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic at_level;
    logic edge_hit;
    always_comb begin
      at_level = ~(irq_in[i] ^ pol_q[i]);
      if (pol_q[i]) edge_hit = irq_in[i] & ~prev_q[i];
      else          edge_hit = ~irq_in[i] & prev_q[i];
    end
    assign set_vec[i]  = trig_q[i] ? edge_hit : at_level;
    assign lvl_hold[i] = ~trig_q[i] & at_level;
  end
endmodule

// File: rtl/irqc_status.sv
module irqc_status
  import irqc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  srcvec_t set_vec,
  input  srcvec_t clr_vec,
  output srcvec_t status_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          status_q[i] <= 1'b0;
      else if (set_vec[i]) status_q[i] <= 1'b1;
      else if (clr_vec[i]) status_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  regofs_t reg_addr,
  input  srcvec_t reg_wdata,
  input  logic    reg_wr,
  input  logic    reg_rd,
  input  srcvec_t status_q,
  output srcvec_t en_q,
  output srcvec_t crit_q,
  output srcvec_t pol_q,
  output srcvec_t trig_q,
  output srcvec_t clr_vec,
  output srcvec_t reg_rdata
);
  srcvec_t rd_word;

  assign clr_vec = clear_of(reg_wr, reg_addr, reg_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_EN:   en_q   <= reg_wdata;
        OFS_CRIT: crit_q <= reg_wdata;
        OFS_POL:  pol_q  <= reg_wdata;
        OFS_TRIG: trig_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT:  rd_word = status_q;
      OFS_EN:    rd_word = en_q;
      OFS_CRIT:  rd_word = crit_q;
      OFS_POL:   rd_word = pol_q;
      OFS_TRIG:  rd_word = trig_q;
      OFS_MSTAT: rd_word = status_q & en_q;
      OFS_VEC:   rd_word = '0;
      OFS_VCFG:  rd_word = '0;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
    else             reg_rdata <= '0;
  end
endmodule

// File: rtl/irq_ctrl32.sv
module irq_ctrl32
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       irq_in,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic              irq_crit,
  output logic              irq_norm
);
  srcvec_t set_vec;
  srcvec_t lvl_hold;
  srcvec_t clr_vec;
  srcvec_t status_q;
  srcvec_t en_q;
  srcvec_t crit_q;
  srcvec_t pol_q;
  srcvec_t trig_q;
  srcvec_t pend_vec;

  irqc_sense u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .trig_q   (trig_q),
    .pol_q    (pol_q),
    .set_vec  (set_vec),
    .lvl_hold (lvl_hold)
  );

  irqc_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .status_q (status_q)
  );

  irqc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .status_q  (status_q),
    .en_q      (en_q),
    .crit_q    (crit_q),
    .pol_q     (pol_q),
    .trig_q    (trig_q),
    .clr_vec   (clr_vec),
    .reg_rdata (reg_rdata)
  );

  assign pend_vec = status_q & en_q;
  assign irq_crit = any_routed(pend_vec, crit_q);
  assign irq_norm = any_routed(pend_vec, ~crit_q);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    reg_wr,
  input srcvec_t set_vec,
  input srcvec_t lvl_hold,
  input srcvec_t clr_vec,
  input srcvec_t status_q,
  input srcvec_t en_q,
  input srcvec_t crit_q,
  input logic    irq_crit,
  input logic    irq_norm
);
  // R3/R4: every capture request lands in status on the next edge.
  assert_capture_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R6: a clear against a held level line leaves the bit set.
  assert_level_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lvl_hold) & $past(clr_vec) & ~status_q) == '0));

  // R5: a status bit only falls where a clear was written.
  assert_fall_needs_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~status_q) & ~$past(clr_vec)) == '0));

  // R5/R11: no clear without a write strobe.
  assert_clear_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |-> (clr_vec == '0));

  // R9: both outputs quiet when nothing enabled is pending.
  assert_quiet_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & en_q) == '0) |-> (!irq_crit && !irq_norm));

  // R10: configuration holds without a write.
  assert_cfg_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(en_q) && $stable(crit_q)));
endmodule

bind irq_ctrl32 irqc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .set_vec  (set_vec),
  .lvl_hold (lvl_hold),
  .clr_vec  (clr_vec),
  .status_q (status_q),
  .en_q     (en_q),
  .crit_q   (crit_q),
  .irq_crit (irq_crit),
  .irq_norm (irq_norm)
);

// File: tb/irq_ctrl32_tb.sv
module irq_ctrl32_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '1;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_crit, irq_norm;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit model_on = 0;

  irq_ctrl32 u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_crit(irq_crit), .irq_norm(irq_norm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model (from the requirements) ----------------
  logic [31:0] m_stat, m_en, m_crit, m_pol, m_trig, m_prev, m_rdata;

  function automatic logic [31:0] exp_status(logic [31:0] old, logic [31:0] inp,
      logic [31:0] prv, logic [31:0] pol, logic [31:0] trg, logic [31:0] clr);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) begin
      logic hit;
      if (trg[b]) hit = pol[b] ? (inp[b] && !prv[b]) : (!inp[b] && prv[b]);
      else        hit = (inp[b] == pol[b]);
      if (hit)         r[b] = 1'b1;
      else if (clr[b]) r[b] = 1'b0;
      else             r[b] = old[b];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] a);
    case (a)
      4'h0: return m_stat;
      4'h2: return m_en;
      4'h3: return m_crit;
      4'h4: return m_pol;
      4'h5: return m_trig;
      4'h6: return m_stat & m_en;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= '0; m_en <= '0; m_crit <= '0; m_pol <= '0;
      m_trig <= '0; m_prev <= '0; m_rdata <= '0;
    end else begin
      m_prev <= irq_in;
      m_stat <= exp_status(m_stat, irq_in, m_prev, m_pol, m_trig,
                           (reg_wr && reg_addr == 4'h0) ? reg_wdata : 32'h0);
      if (reg_wr) begin
        if (reg_addr == 4'h2) m_en   <= reg_wdata;
        if (reg_addr == 4'h3) m_crit <= reg_wdata;
        if (reg_addr == 4'h4) m_pol  <= reg_wdata;
        if (reg_addr == 4'h5) m_trig <= reg_wdata;
      end
      m_rdata <= reg_rd ? exp_read(reg_addr) : 32'h0;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(logic [3:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R2 crit in reset", {31'b0, irq_crit}, 32'h0);
    check("R2 norm in reset", {31'b0, irq_norm}, 32'h0);
    check("R2 rdata in reset", reg_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset values (inputs idle high, active-low level not reached)
    do_read(4'h0, rd); check("R2 status", rd, 32'h0);
    do_read(4'h2, rd); check("R2 enable", rd, 32'h0);
    do_read(4'h3, rd); check("R2 critsel", rd, 32'h0);
    do_read(4'h4, rd); check("R2 polarity", rd, 32'h0);
    do_read(4'h5, rd); check("R2 trigger", rd, 32'h0);

    // Move every source to active-high level without a spurious capture
    do_write(4'h5, 32'hFFFF_FFFF);
    do_write(4'h4, 32'hFFFF_FFFF);
    irq_in = '0;
    do_write(4'h5, 32'h0);
    do_write(4'h2, 32'hFFFF_FFFF);
    do_write(4'h3, 32'h0);
    do_read(4'h4, rd); check("R10 polarity readback", rd, 32'hFFFF_FFFF);
    do_read(4'h5, rd); check("R10 trigger readback", rd, 32'h0);
    do_read(4'h2, rd); check("R10 enable readback", rd, 32'hFFFF_FFFF);
    do_read(4'h0, rd); check("R3 no capture while idle", rd, 32'h0);

    // R1/R3: source 0 on the MSB, level high
    irq_in = 32'h8000_0000;
    @(negedge clk);
    check("R3 norm after level", {31'b0, irq_norm}, 32'h1);
    check("R9 crit stays low", {31'b0, irq_crit}, 32'h0);
    do_read(4'h6, rd); check("R1 source0 is bit31", rd, 32'h8000_0000);
    // R6: clear while held, enabled then disabled
    do_write(4'h0, 32'hFFFF_FFFF);
    do_read(4'h0, rd); check("R6 held level survives clear", rd, 32'h8000_0000);
    do_write(4'h2, 32'h0);
    do_write(4'h0, 32'hFFFF_FFFF);
    do_read(4'h0, rd); check("R6 held while disabled", rd, 32'h8000_0000);
    check("R9 norm low when disabled", {31'b0, irq_norm}, 32'h0);
    irq_in = '0;
    do_write(4'h0, 32'hFFFF_FFFF);
    do_read(4'h0, rd); check("R5 clear after release", rd, 32'h0);

    // R1/R8: source 31 on bit 0, captured while disabled
    irq_in = 32'h1;
    @(negedge clk);
    irq_in = '0;
    @(negedge clk);
    do_read(4'h0, rd); check("R1 source31 is bit0", rd, 32'h1);
    do_read(4'h6, rd); check("R8 masked hides disabled", rd, 32'h0);
    check("R8 outputs low", {30'b0, irq_crit, irq_norm}, 32'h0);
    do_write(4'h2, 32'h1);
    check("R9 norm routes", {30'b0, irq_crit, irq_norm}, 32'h1);
    do_read(4'h6, rd); check("R8 masked shows enabled", rd, 32'h1);
    do_write(4'h3, 32'h1);
    check("R9 crit routes", {30'b0, irq_crit, irq_norm}, 32'h2);
    do_write(4'h0, 32'hFFFF_FFFE);
    do_read(4'h0, rd); check("R5 zero bits keep status", rd, 32'h1);
    do_write(4'h0, 32'h1);
    check("R5 clear drops crit", {30'b0, irq_crit, irq_norm}, 32'h0);

    // R4: edge sensing, bits 4,5 rising and bits 6,7 falling
    do_write(4'h5, 32'h0000_00F0);
    do_write(4'h4, ~32'h0000_00C0);
    irq_in = 32'h0000_00F0;
    @(negedge clk);
    do_read(4'h0, rd); check("R4 rising edges", rd, 32'h0000_0030);
    irq_in = '0;
    @(negedge clk);
    do_read(4'h0, rd); check("R4 falling edges and hold", rd, 32'h0000_00F0);

    // R7: new edge and clear in the same cycle
    irq_in = 32'h0000_0010;
    do_write(4'h0, 32'h0000_00F0);
    irq_in = '0;
    do_read(4'h0, rd); check("R7 set beats clear", rd, 32'h0000_0010);
    do_write(4'h0, 32'h0000_0010);
    do_read(4'h0, rd); check("R5 edge bit cleared", rd, 32'h0);

    // R11: ignored writes and zero reads
    do_write(4'h6, 32'hFFFF_FFFF);
    do_write(4'h7, 32'hFFFF_FFFF);
    do_write(4'h8, 32'hFFFF_FFFF);
    do_write(4'hF, 32'hFFFF_FFFF);
    do_write(4'h1, 32'hFFFF_FFFF);
    do_read(4'h2, rd); check("R11 enable untouched", rd, 32'h1);
    do_read(4'h3, rd); check("R11 critsel untouched", rd, 32'h1);
    do_read(4'h4, rd); check("R11 polarity untouched", rd, ~32'h0000_00C0);
    do_read(4'h5, rd); check("R11 trigger untouched", rd, 32'h0000_00F0);
    do_read(4'h0, rd); check("R11 status untouched", rd, 32'h0);
    do_read(4'h7, rd); check("R11 vector reads zero", rd, 32'h0);
    do_read(4'h8, rd); check("R11 vector cfg reads zero", rd, 32'h0);
    do_read(4'hF, rd); check("R11 unmapped reads zero", rd, 32'h0);
    do_read(4'h2, rd);
    @(negedge clk);
    check("R12 rdata zero without strobe", reg_rdata, 32'h0);

    // Random traffic judged by the model
    model_on = 1;
    for (int c = 0; c < RAND_CYCLES; c++) begin
      irq_in    = $urandom;
      reg_wr    = ($urandom_range(3) == 0);
      reg_addr  = ($urandom_range(7) == 0) ? 4'($urandom_range(15)) : 4'($urandom_range(6));
      reg_wdata = ($urandom_range(1) == 0) ? $urandom : 32'hFFFF_FFFF;
      reg_rd    = ($urandom_range(1) == 0);
      @(negedge clk);
      check("R12 random read data", reg_rdata, m_rdata);
      check("R9 random outputs", {30'b0, irq_crit, irq_norm},
            {30'b0, |(m_stat & m_en & m_crit), |(m_stat & m_en & ~m_crit)});
    end
    reg_wr = 1'b0; reg_rd = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule